// File: doc/BRIEF.md
# Overlapping Register Window File

This block is a register file whose registers are grouped into windows arranged in a circular buffer. Each window shows the software three groups of eight registers: incoming arguments, locals, and outgoing arguments. A fourth group of eight globals is shared by all windows. The outgoing group of one window is physically the same storage as the incoming group of the next window. A caller therefore places arguments in its outgoing registers, and after the call they appear in the callee's incoming registers without being copied.

A current-window index selects the active window. A call advances the index by one, a return moves it back by one, and both wrap around the buffer. A saved-window index marks the boundary with windows that have been moved out to memory. When a call would run into that boundary, the block raises an overflow trap request and holds the call. When a return would enter a window that is no longer resident, it raises an underflow trap request. A handler performs the memory transfer and then pulses the matching acknowledge. The acknowledge moves the saved index and completes the held call or return.

The block has two combinational read ports and one synchronous write port, all addressed by a 5-bit architectural register number.

Top module: `winreg_file`

## Requirements
- R1: After reset, both window indexes are 0, both trap requests are low, and every register reads 0.
- R2: Register numbers 0-7 select globals, 8-15 outgoing, 16-23 locals, and 24-31 incoming. Globals read the same from every window. Locals and incoming registers belong to one window only.
- R3: A call with no trap pending, whose next window (current + 1, wrapping from NUM_WIN-1 to 0) differs from the saved index, advances the current index by one. Outgoing register 8+k of the caller then reads as incoming register 24+k of the callee.
- R4: A return with no trap pending, when the current index differs from the saved index, moves the current index back by one with wrap. The caller's locals read back unchanged, and the callee's incoming register 24+k reads as the caller's outgoing register 8+k.
- R5: A call whose next window equals the saved index raises the overflow request and leaves the current index unchanged. While either request is high, calls and returns are ignored.
- R6: An overflow acknowledge while overflow is requested advances the saved index by one, commits the held call (current index + 1), and clears the request, all on the same edge.
- R7: A return when the current index equals the saved index raises the underflow request and leaves the current index unchanged.
- R8: An underflow acknowledge while underflow is requested moves the saved index back by one, completes the held return (current index - 1), and clears the request.
- R9: An acknowledge with no matching request pending changes neither index nor either request.
- R10: Register 0 always reads 0 on both ports, and writes to it are dropped.
- R11: A read whose address matches an enabled write in the same cycle returns the write data before the edge (write-first).
- R12: When call and return are both asserted, the call takes precedence.
- R13: A write in the same cycle as a call goes to the window that was current before the call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_i | input | 1 | Procedure call: advance window |
| ret_i | input | 1 | Procedure return: retreat window |
| spill_ack_i | input | 1 | Overflow handled; oldest window saved |
| fill_ack_i | input | 1 | Underflow handled; window restored |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Write architectural register number |
| wr_data_i | input | 32 | Write data |
| rd_a_addr_i | input | 5 | Read port A register number |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_addr_i | input | 5 | Read port B register number |
| rd_b_data_o | output | 32 | Read port B data |
| cwp_o | output | 3 | Current window index |
| swp_o | output | 3 | Saved window index |
| ovf_req_o | output | 1 | Overflow trap request |
| unf_req_o | output | 1 | Underflow trap request |

## Verification
A wrong current-window index shows on the first read of a local or incoming register after the faulty call or return. The read returns another window's data, usually within one cycle. A wrong saved index stays hidden until the buffer fills or drains, when the overflow or underflow request appears one call too early or too late. The tests therefore walk the full depth of the buffer and check both indexes on every step. A wrong alias between outgoing and incoming registers shows as lost arguments on the first read after a call or return.

// File: rtl/winreg_pkg.sv
package winreg_pkg;
    // Register group selected by the top two bits of an architectural number.
    // The encoding is behavioural: software relies on these ranges.
    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'd0,
        GRP_OUT    = 2'd1,
        GRP_LOCAL  = 2'd2,
        GRP_IN     = 2'd3
    } reg_grp_e;
endpackage

// File: rtl/winreg_addr_map.sv
module winreg_addr_map #(
    parameter int NUM_WIN  = 8,
    parameter int GRP_REGS = 8,
    localparam int GI_W    = $clog2(GRP_REGS),
    localparam int AW      = GI_W + 2,
    localparam int WP_W    = $clog2(NUM_WIN),
    localparam int PHYS    = NUM_WIN * 2 * GRP_REGS + GRP_REGS,
    localparam int PA_W    = $clog2(PHYS)
) (
    input  logic [AW-1:0]   arch_i,
    input  logic [WP_W-1:0] cwp_i,
    output logic [PA_W-1:0] pa_o
);
    import winreg_pkg::*;

    // Layout: globals at rows 0..GRP_REGS-1; window w owns 2*GRP_REGS rows
    // starting at GRP_REGS + w*2*GRP_REGS (incoming first, then locals).
    // Outgoing registers of window w are the incoming rows of window w+1.
    reg_grp_e          grp;
    logic [GI_W-1:0]   idx;
    logic [WP_W-1:0]   win_nxt;
    logic [PA_W-1:0]   base_cur;
    logic [PA_W-1:0]   base_nxt;

    always_comb begin
        grp      = reg_grp_e'(arch_i[AW-1 -: 2]);
        idx      = arch_i[GI_W-1:0];
        win_nxt  = (cwp_i == WP_W'(NUM_WIN - 1)) ? '0 : cwp_i + 1'b1;
        base_cur = PA_W'(GRP_REGS) + PA_W'(cwp_i) * PA_W'(2 * GRP_REGS);
        base_nxt = PA_W'(GRP_REGS) + PA_W'(win_nxt) * PA_W'(2 * GRP_REGS);
        unique case (grp)
            GRP_GLOBAL: pa_o = PA_W'(idx);
            GRP_OUT:    pa_o = base_nxt + PA_W'(idx);
            GRP_LOCAL:  pa_o = base_cur + PA_W'(GRP_REGS) + PA_W'(idx);
            default:    pa_o = base_cur + PA_W'(idx);
        endcase
    end
endmodule

// File: rtl/winreg_ptr_ctrl.sv
module winreg_ptr_ctrl #(
    parameter int NUM_WIN = 8,
    localparam int WP_W   = $clog2(NUM_WIN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            call_i,
    input  logic            ret_i,
    input  logic            spill_ack_i,
    input  logic            fill_ack_i,
    output logic [WP_W-1:0] cwp_o,
    output logic [WP_W-1:0] swp_o,
    output logic            ovf_o,
    output logic            unf_o
);
    typedef struct packed {
        logic [WP_W-1:0] cwp;
        logic [WP_W-1:0] swp;
        logic            ovf;
        logic            unf;
    } ptr_state_t;

    ptr_state_t      st_d, st_q;
    logic [WP_W-1:0] cwp_inc, cwp_dec;

    function automatic logic [WP_W-1:0] wrap_inc(input logic [WP_W-1:0] v);
        return (v == WP_W'(NUM_WIN - 1)) ? '0 : v + 1'b1;
    endfunction

    function automatic logic [WP_W-1:0] wrap_dec(input logic [WP_W-1:0] v);
        return (v == '0) ? WP_W'(NUM_WIN - 1) : v - 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        cwp_inc = wrap_inc(st_q.cwp);
        cwp_dec = wrap_dec(st_q.cwp);
        if (st_q.ovf) begin
            // held call completes once the oldest window is saved
            if (spill_ack_i) begin
                st_d.swp = wrap_inc(st_q.swp);
                st_d.cwp = cwp_inc;
                st_d.ovf = 1'b0;
            end
        end else if (st_q.unf) begin
            // held return completes once the window is restored
            if (fill_ack_i) begin
                st_d.swp = wrap_dec(st_q.swp);
                st_d.cwp = cwp_dec;
                st_d.unf = 1'b0;
            end
        end else if (call_i) begin
            if (cwp_inc == st_q.swp) st_d.ovf = 1'b1;
            else                     st_d.cwp = cwp_inc;
        end else if (ret_i) begin
            if (st_q.cwp == st_q.swp) st_d.unf = 1'b1;
            else                      st_d.cwp = cwp_dec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cwp_o = st_q.cwp;
    assign swp_o = st_q.swp;
    assign ovf_o = st_q.ovf;
    assign unf_o = st_q.unf;

    assert_one_trap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.ovf && st_q.unf));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ovf && !st_q.unf && call_i && wrap_inc(st_q.cwp) == st_q.swp)
        |=> (st_q.ovf && $stable(st_q.cwp)));

    assert_ovf_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && !spill_ack_i) |=> (st_q.ovf && $stable(st_q.cwp) && $stable(st_q.swp)));

    assert_spill_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && spill_ack_i)
        |=> (!st_q.ovf && st_q.swp == wrap_inc($past(st_q.swp)) && st_q.cwp == wrap_inc($past(st_q.cwp))));

    assert_fill_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.unf && fill_ack_i)
        |=> (!st_q.unf && st_q.swp == wrap_dec($past(st_q.swp)) && st_q.cwp == wrap_dec($past(st_q.cwp))));

    assert_swp_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ovf && !st_q.unf) |=> $stable(st_q.swp));
endmodule

// File: rtl/winreg_store.sv
module winreg_store #(
    parameter int DATA_W = 32,
    parameter int PHYS   = 136,
    parameter int NRD    = 2,
    localparam int PA_W  = $clog2(PHYS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic [PA_W-1:0]            wr_pa_i,
    input  logic [DATA_W-1:0]          wr_data_i,
    input  logic [NRD-1:0][PA_W-1:0]   rd_pa_i,
    output logic [NRD-1:0][DATA_W-1:0] rd_data_o
);
    logic [DATA_W-1:0] mem_d [PHYS];
    logic [DATA_W-1:0] mem_q [PHYS];
    logic              wr_live;

    // row 0 is the hard-wired zero register: never written
    assign wr_live = wr_en_i && (wr_pa_i != '0);

    always_comb begin
        for (int i = 0; i < PHYS; i++) mem_d[i] = mem_q[i];
        if (wr_live) mem_d[wr_pa_i] = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PHYS; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < PHYS; i++) mem_q[i] <= mem_d[i];
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (wr_live && wr_pa_i == rd_pa_i[p]) rd_data_o[p] = wr_data_i;
            else                                  rd_data_o[p] = mem_q[rd_pa_i[p]];
        end
    end
endmodule

// File: rtl/winreg_file.sv
module winreg_file #(
    parameter int NUM_WIN  = 8,
    parameter int GRP_REGS = 8,
    parameter int DATA_W   = 32,
    localparam int AW      = $clog2(GRP_REGS) + 2,
    localparam int WP_W    = $clog2(NUM_WIN),
    localparam int PHYS    = NUM_WIN * 2 * GRP_REGS + GRP_REGS,
    localparam int PA_W    = $clog2(PHYS),
    localparam int NRD     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic              spill_ack_i,
    input  logic              fill_ack_i,
    input  logic              wr_en_i,
    input  logic [AW-1:0]     wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [AW-1:0]     rd_a_addr_i,
    output logic [DATA_W-1:0] rd_a_data_o,
    input  logic [AW-1:0]     rd_b_addr_i,
    output logic [DATA_W-1:0] rd_b_data_o,
    output logic [WP_W-1:0]   cwp_o,
    output logic [WP_W-1:0]   swp_o,
    output logic              ovf_req_o,
    output logic              unf_req_o
);
    // port 0 = write, ports 1..NRD = reads
    logic [NRD:0][AW-1:0]       arch_all;
    logic [NRD:0][PA_W-1:0]     pa_all;
    logic [NRD-1:0][PA_W-1:0]   rd_pa;
    logic [NRD-1:0][DATA_W-1:0] rd_data;
    logic [WP_W-1:0]            cwp;

    assign arch_all = {rd_b_addr_i, rd_a_addr_i, wr_addr_i};
    assign rd_pa    = pa_all[NRD:1];

    winreg_ptr_ctrl #(.NUM_WIN(NUM_WIN)) ptr_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .call_i      (call_i),
        .ret_i       (ret_i),
        .spill_ack_i (spill_ack_i),
        .fill_ack_i  (fill_ack_i),
        .cwp_o       (cwp),
        .swp_o       (swp_o),
        .ovf_o       (ovf_req_o),
        .unf_o       (unf_req_o)
    );

    for (genvar p = 0; p <= NRD; p++) begin : g_map
        winreg_addr_map #(.NUM_WIN(NUM_WIN), .GRP_REGS(GRP_REGS)) map_i (
            .arch_i (arch_all[p]),
            .cwp_i  (cwp),
            .pa_o   (pa_all[p])
        );
    end

    winreg_store #(.DATA_W(DATA_W), .PHYS(PHYS), .NRD(NRD)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_pa_i   (pa_all[0]),
        .wr_data_i (wr_data_i),
        .rd_pa_i   (rd_pa),
        .rd_data_o (rd_data)
    );

    assign rd_a_data_o = rd_data[0];
    assign rd_b_data_o = rd_data[1];
    assign cwp_o       = cwp;

    assert_zero_reg_a_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_addr_i == '0) |-> (rd_a_data_o == '0));

    assert_zero_reg_b_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_addr_i == '0) |-> (rd_b_data_o == '0));

    assert_cwp_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cwp_o == $past(cwp_o)
               || cwp_o == (($past(cwp_o) == WP_W'(NUM_WIN - 1)) ? '0 : $past(cwp_o) + 1'b1)
               || cwp_o == (($past(cwp_o) == '0) ? WP_W'(NUM_WIN - 1) : $past(cwp_o) - 1'b1)));
endmodule

// File: tb/winreg_file_tb_top.sv
module winreg_file_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_i = 0, ret_i = 0, spill_ack_i = 0, fill_ack_i = 0;
    logic        wr_en_i = 0;
    logic [4:0]  wr_addr_i = '0, rd_a_addr_i = '0, rd_b_addr_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] rd_a_data_o, rd_b_data_o;
    logic [2:0]  cwp_o, swp_o;
    logic        ovf_req_o, unf_req_o;

    int checks = 0;
    int errors = 0;
    bit summary_done = 0;

    always #2 clk = ~clk;

    winreg_file dut_i (
        .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
        .spill_ack_i(spill_ack_i), .fill_ack_i(fill_ack_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_a_addr_i(rd_a_addr_i), .rd_a_data_o(rd_a_data_o),
        .rd_b_addr_i(rd_b_addr_i), .rd_b_data_o(rd_b_data_o),
        .cwp_o(cwp_o), .swp_o(swp_o), .ovf_req_o(ovf_req_o), .unf_req_o(unf_req_o)
    );

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        {call_i, ret_i, spill_ack_i, fill_ack_i, wr_en_i} = '0;
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
        step();
        wr_en_i = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        rd_a_addr_i = a;
        #1;
        d = rd_a_data_o;
    endtask

    task automatic pulse_call();
        call_i = 1; step(); call_i = 0;
    endtask

    task automatic pulse_ret();
        ret_i = 1; step(); ret_i = 0;
    endtask

    task automatic chk_ptrs(input string tag, input int c, input int s, input bit o, input bit u);
        chk({tag, " cwp"}, 32'(cwp_o), 32'(c));
        chk({tag, " swp"}, 32'(swp_o), 32'(s));
        chk({tag, " ovf"}, 32'(ovf_req_o), 32'(o));
        chk({tag, " unf"}, 32'(unf_req_o), 32'(u));
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        chk_ptrs("R1 reset", 0, 0, 0, 0);
        rd(5'd17, d);
        chk("R1 local cleared", d, 32'h0);
    endtask

    task automatic t_groups();
        logic [31:0] d;
        do_reset();
        wr(5'd3, 32'hA3);
        wr(5'd18, 32'h1002);
        pulse_call();
        rd(5'd3, d);  chk("R2 global seen from window 1", d, 32'hA3);
        rd(5'd18, d); chk("R2 callee local is separate", d, 32'h0);
        wr(5'd4, 32'hB4);
        wr(5'd18, 32'h2002);
        pulse_ret();
        rd(5'd4, d);  chk("R2 global written in callee", d, 32'hB4);
        rd(5'd18, d); chk("R4 caller local restored", d, 32'h1002);
    endtask

    task automatic t_pass();
        logic [31:0] d;
        do_reset();
        wr(5'd13, 32'h55);
        pulse_call();
        chk("R3 cwp after call", 32'(cwp_o), 32'd1);
        rd(5'd29, d); chk("R3 out 13 -> in 29", d, 32'h55);
        wr(5'd25, 32'h77);
        pulse_ret();
        chk("R4 cwp after return", 32'(cwp_o), 32'd0);
        rd(5'd9, d); chk("R4 in 25 -> out 9", d, 32'h77);
        rd_b_addr_i = 5'd13; #1;
        chk("R3 port B out 13", rd_b_data_o, 32'h55);
    endtask

    task automatic t_overflow();
        do_reset();
        for (int i = 1; i <= 7; i++) begin
            pulse_call();
            chk("R3 cwp walk", 32'(cwp_o), 32'(i));
        end
        chk("R5 no overflow before full", 32'(ovf_req_o), 32'd0);
        pulse_call();
        chk_ptrs("R5 full call", 7, 0, 1, 0);
        call_i = 1; ret_i = 1; step(); call_i = 0; ret_i = 0;
        chk_ptrs("R5 blocked while pending", 7, 0, 1, 0);
        spill_ack_i = 1; step(); spill_ack_i = 0;
        chk_ptrs("R6 spill ack commits call (wrap)", 0, 1, 0, 0);
        pulse_call();
        chk_ptrs("R5 full again after wrap", 0, 1, 1, 0);
    endtask

    task automatic t_underflow();
        do_reset();
        pulse_ret();
        chk_ptrs("R7 return into spilled window", 0, 0, 0, 1);
        pulse_call();
        chk_ptrs("R7 call ignored while pending", 0, 0, 0, 1);
        fill_ack_i = 1; step(); fill_ack_i = 0;
        chk_ptrs("R8 fill ack completes return", 7, 7, 0, 0);
        pulse_call();
        chk_ptrs("R8 call after fill", 0, 7, 0, 0);
    endtask

    task automatic t_idle_acks();
        do_reset();
        pulse_call();
        spill_ack_i = 1; step(); spill_ack_i = 0;
        chk_ptrs("R9 stray spill ack", 1, 0, 0, 0);
        fill_ack_i = 1; step(); fill_ack_i = 0;
        chk_ptrs("R9 stray fill ack", 1, 0, 0, 0);
    endtask

    task automatic t_zero();
        logic [31:0] d;
        do_reset();
        wr(5'd0, 32'hDEAD);
        rd(5'd0, d); chk("R10 port A reg 0", d, 32'h0);
        rd_b_addr_i = 5'd0; #1;
        chk("R10 port B reg 0", rd_b_data_o, 32'h0);
        wr_en_i = 1; wr_addr_i = 5'd0; wr_data_i = 32'hBEEF; rd_a_addr_i = 5'd0; #1;
        chk("R10 no bypass on reg 0", rd_a_data_o, 32'h0);
        step(); wr_en_i = 0;
    endtask

    task automatic t_bypass();
        do_reset();
        wr(5'd20, 32'h1);
        wr_en_i = 1; wr_addr_i = 5'd20; wr_data_i = 32'hBEEF;
        rd_a_addr_i = 5'd20; rd_b_addr_i = 5'd20; #1;
        chk("R11 bypass port A", rd_a_data_o, 32'hBEEF);
        chk("R11 bypass port B", rd_b_data_o, 32'hBEEF);
        step(); wr_en_i = 0; #1;
        chk("R11 value kept", rd_a_data_o, 32'hBEEF);
    endtask

    task automatic t_both();
        do_reset();
        call_i = 1; ret_i = 1; step(); call_i = 0; ret_i = 0;
        chk_ptrs("R12 call wins", 1, 0, 0, 0);
    endtask

    task automatic t_write_call();
        logic [31:0] d;
        do_reset();
        call_i = 1; wr_en_i = 1; wr_addr_i = 5'd16; wr_data_i = 32'h13;
        step();
        call_i = 0; wr_en_i = 0;
        rd(5'd16, d); chk("R13 new window untouched", d, 32'h0);
        pulse_ret();
        rd(5'd16, d); chk("R13 write landed in old window", d, 32'h13);
    endtask

    initial begin
        t_reset();
        t_groups();
        t_pass();
        t_overflow();
        t_underflow();
        t_idle_acks();
        t_zero();
        t_bypass();
        t_both();
        t_write_call();
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired got=running exp=done");
        summary();
        $finish;
    end
endmodule